// File: doc/BRIEF.md
# Pseudorandom Self-Test with Serial Signature Check

This block is a compact built-in self-test engine. A three-stage maximal-length shift register with XOR feedback generates a pseudorandom sequence of test vectors. Those vectors drive a small fixed combinational function, the circuit under test. The single response bit of that function is folded into a three-stage serial-input signature register. After one full period of the generator, the block compares the compacted signature against a stored good value. It then raises a done flag and a pass/fail verdict.

A test run begins from the active-low init. The run stays idle until a start request is seen. The edge on which start is first sampled high counts as the first of seven stepping edges. When the seventh edge has passed, both shift registers hold their values until the next init. A fault-injection control forces the response bit to a constant 1, which models a stuck-at-1 output. With that control set, the signature must differ from the good value and the verdict must be fail. All pins are plain control or status signals. There is no streaming interface, so no valid/ready handshake and no back-pressure rules apply.

Top module: `lfsr_sig_bist`

## Requirements
- R1: While init_n is low, gen_q reads 3'b100, sig_q reads 3'b000, and done and pass are 0.
- R2: After init, while start is low and no run has begun, gen_q and sig_q keep their init values.
- R3: gen_q is {Q0,Q1,Q2} with Q0 in bit 2. Each stepping edge loads Q0 with Q1 XOR Q2, Q1 with the old Q0, and Q2 with the old Q1. Starting from 4, this gives the hex sequence 2, 5, 6, 7, 3, 1, 4.
- R4: The generator never holds or enters the all-zeros state.
- R5: The response bit is (NOT Q0 AND Q1) OR (Q1 AND Q2). sig_q is {R0,R1,R2} with R0 in bit 2. Each stepping edge loads R0 with response XOR R0 XOR R2, R1 with the old R0, and R2 with the old R1. For a good circuit, the values after edges 1 to 7 are hex 0, 4, 6, 7, 7, 7, 3.
- R6: The edge that samples start high while idle is stepping edge 1. done rises exactly at stepping edge 7.
- R7: Once done is high, gen_q, sig_q, done and pass stay constant whatever start and fault_en do, until init_n goes low.
- R8: pass becomes 1 together with done when the final signature equals 3'b011. pass is 0 whenever done is 0.
- R9: With fault_en held at 1, the response bit is 1 on every edge. sig_q then runs hex 4, 2, 5, 6, 3, 1, 0, and pass stays 0 when done rises.
- R10: Driving init_n low in the middle of a run restores the R1 state at once. A following start runs a complete new test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| init_n | input | 1 | Asynchronous active-low init |
| start | input | 1 | Begin a run while idle |
| fault_en | input | 1 | Force the response bit to 1 (stuck-at-1) |
| gen_q | output | 3 | Generator state {Q0,Q1,Q2} |
| sig_q | output | 3 | Signature register {R0,R1,R2} |
| done | output | 1 | Run complete, registers frozen |
| pass | output | 1 | Final signature equals the good value |

## Verification
The run is tried three ways. The first is a fault-free run, which checks every intermediate generator and signature value against hand-computed tables. The second is a run with the stuck-at-1 control held, which must end in a different signature (000) and a fail verdict. The third is an init pulse in the middle of a run followed by a clean rerun, which shows that the counter and both registers are fully restored. Idle cycles with start low, and cycles after done with start and fault_en toggled, show that nothing moves outside a run.

// File: rtl/sigbist_pkg.sv
package sigbist_pkg;
  localparam int unsigned SB_W = 3;
  localparam logic [SB_W-1:0] SB_GEN_SEED = 3'b100;
  localparam logic [SB_W-1:0] SB_GEN_MASK = 3'b011; // taps on Q1, Q2
  localparam logic [SB_W-1:0] SB_SIG_MASK = 3'b101; // taps on R0, R2
  localparam logic [SB_W-1:0] SB_GOOD_SIG = 3'b011;
endpackage

// File: rtl/shift_fb_reg.sv
module shift_fb_reg #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] SEED = '0,
  parameter logic [W-1:0] MASK = '0
) (
  input  logic         clk,
  input  logic         init_n,
  input  logic         adv,
  input  logic         ser_in,
  output logic [W-1:0] q,
  output logic [W-1:0] q_nxt
);
  // bit W-1 is stage 0; the value shifts toward bit 0
  logic [W-1:0] tap_x;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_tap
      if (gi == 0) begin : g_first
        assign tap_x[gi] = MASK[gi] & q[gi];
      end else begin : g_rest
        assign tap_x[gi] = tap_x[gi-1] ^ (MASK[gi] & q[gi]);
      end
    end
  endgenerate

  assign q_nxt = {ser_in ^ tap_x[W-1], q[W-1:1]};

  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n) q <= SEED;
    else if (adv) q <= q_nxt;
  end
endmodule

// File: rtl/cut_logic.sv
module cut_logic (
  input  logic [2:0] vec,
  input  logic       fault_en,
  output logic       z
);
  logic s0, s1, s2;
  assign s0 = vec[2];
  assign s1 = vec[1];
  assign s2 = vec[0];
  assign z  = fault_en | ((~s0 & s1) | (s1 & s2));
endmodule

// File: rtl/run_ctrl.sv
module run_ctrl #(
  parameter int unsigned RUN_LEN = 7
) (
  input  logic clk,
  input  logic init_n,
  input  logic start,
  output logic adv,
  output logic last,
  output logic done
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt;
  logic          busy;

  assign adv  = ~done & (busy | start);
  assign last = (cnt == LAST_CNT);

  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else if (adv) begin
      cnt <= cnt + 1'b1;
      if (last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        busy <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lfsr_sig_bist.sv
module lfsr_sig_bist
  import sigbist_pkg::*;
#(
  parameter int unsigned W = SB_W,
  parameter logic [W-1:0] GEN_SEED = SB_GEN_SEED,
  parameter logic [W-1:0] GEN_MASK = SB_GEN_MASK,
  parameter logic [W-1:0] SIG_MASK = SB_SIG_MASK,
  parameter logic [W-1:0] GOOD_SIG = SB_GOOD_SIG
) (
  input  logic         clk,
  input  logic         init_n,
  input  logic         start,
  input  logic         fault_en,
  output logic [W-1:0] gen_q,
  output logic [W-1:0] sig_q,
  output logic         done,
  output logic         pass
);
  localparam int unsigned RUN_LEN = (1 << W) - 1;

  logic         adv, last, resp;
  logic [W-1:0] gen_nxt, sig_nxt;

  run_ctrl #(.RUN_LEN(RUN_LEN)) u_ctrl (
    .clk(clk), .init_n(init_n), .start(start),
    .adv(adv), .last(last), .done(done)
  );

  shift_fb_reg #(.W(W), .SEED(GEN_SEED), .MASK(GEN_MASK)) u_gen (
    .clk(clk), .init_n(init_n), .adv(adv), .ser_in(1'b0),
    .q(gen_q), .q_nxt(gen_nxt)
  );

  cut_logic u_cut (.vec(gen_q), .fault_en(fault_en), .z(resp));

  shift_fb_reg #(.W(W), .SEED('0), .MASK(SIG_MASK)) u_sig (
    .clk(clk), .init_n(init_n), .adv(adv), .ser_in(resp),
    .q(sig_q), .q_nxt(sig_nxt)
  );

  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n) pass <= 1'b0;
    else if (adv && last) pass <= (sig_nxt == GOOD_SIG);
  end
endmodule

// File: rtl/sigbist_chk.sv
module sigbist_chk #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] GEN_SEED = 3'b100,
  parameter logic [W-1:0] GOOD_SIG = 3'b011
) (
  input logic         clk,
  input logic         init_n,
  input logic [W-1:0] gen_q,
  input logic [W-1:0] gen_nxt,
  input logic [W-1:0] sig_q,
  input logic         done,
  input logic         pass
);
  // R4
  gen_nonzero_chk: assert property (@(posedge clk) disable iff (!init_n)
    (gen_q != '0) && (gen_nxt != '0));

  // R7
  frozen_after_done_chk: assert property (@(posedge clk) disable iff (!init_n)
    done |=> done && $stable(gen_q) && $stable(sig_q) && $stable(pass));

  // R8
  pass_needs_done_chk: assert property (@(posedge clk) disable iff (!init_n)
    !done |-> !pass);

  // R8
  verdict_matches_chk: assert property (@(posedge clk) disable iff (!init_n)
    $rose(done) |-> (pass == (sig_q == GOOD_SIG)));

  // R6
  full_period_chk: assert property (@(posedge clk) disable iff (!init_n)
    $rose(done) |-> (gen_q == GEN_SEED));
endmodule

bind lfsr_sig_bist sigbist_chk #(.W(W), .GEN_SEED(GEN_SEED), .GOOD_SIG(GOOD_SIG)) u_chk (
  .clk(clk), .init_n(init_n), .gen_q(gen_q), .gen_nxt(gen_nxt),
  .sig_q(sig_q), .done(done), .pass(pass)
);

// File: tb/sim_lfsr_sig_bist.sv
module sim_lfsr_sig_bist;
  localparam int CLK_P = 10;

  typedef struct {
    logic [2:0] gen;
    logic [2:0] sig;
    logic       dn;
    logic       ps;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic init_n = 1'b0;
  logic start = 1'b0;
  logic fault_en = 1'b0;
  logic [2:0] gen_q, sig_q;
  logic done, pass;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  exp_t sb[$];

  // expected tables after stepping edges 1..7
  logic [2:0] gen_tab [7] = '{3'h2, 3'h5, 3'h6, 3'h7, 3'h3, 3'h1, 3'h4};
  logic [2:0] good_tab[7] = '{3'h0, 3'h4, 3'h6, 3'h7, 3'h7, 3'h7, 3'h3};
  logic [2:0] bad_tab [7] = '{3'h4, 3'h2, 3'h5, 3'h6, 3'h3, 3'h1, 3'h0};

  lfsr_sig_bist u0 (
    .clk(clk), .init_n(init_n), .start(start), .fault_en(fault_en),
    .gen_q(gen_q), .sig_q(sig_q), .done(done), .pass(pass)
  );

  always #(CLK_P/2) clk = ~clk;

  // monitor: compare after each edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (gen_q !== e.gen || sig_q !== e.sig || done !== e.dn || pass !== e.ps) begin
        errors++;
        $display("FAIL %s: got gen=%h sig=%h done=%b pass=%b expected gen=%h sig=%h done=%b pass=%b",
                 e.tag, gen_q, sig_q, done, pass, e.gen, e.sig, e.dn, e.ps);
      end
      checks++;
      if (gen_q === 3'h0) begin
        errors++;
        $display("FAIL R4: got gen=%h expected nonzero", gen_q);
      end
    end
  end

  task automatic drive(input logic rn, input logic st, input logic fe,
                       input logic [2:0] g, input logic [2:0] s,
                       input logic d, input logic p, input string tag);
    exp_t e;
    init_n = rn; start = st; fault_en = fe;
    e.gen = g; e.sig = s; e.dn = d; e.ps = p; e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
    #4;
  endtask

  task automatic full_run(input logic fe, input string tag);
    for (int k = 0; k < 7; k++)
      drive(1'b1, 1'b1, fe, gen_tab[k], fe ? bad_tab[k] : good_tab[k],
            k == 6, (k == 6) && !fe, tag);
  endtask

  initial begin
    #1;
    drive(1'b0, 1'b0, 1'b0, 3'h4, 3'h0, 0, 0, "R1 init");
    drive(1'b0, 1'b1, 1'b1, 3'h4, 3'h0, 0, 0, "R1 init");
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 1'b0, 3'h4, 3'h0, 0, 0, "R2 idle");
    full_run(1'b0, "R3/R5/R6/R8 good run");
    drive(1'b1, 1'b1, 1'b0, 3'h4, 3'h3, 1, 1, "R7 frozen");
    drive(1'b1, 1'b0, 1'b1, 3'h4, 3'h3, 1, 1, "R7 frozen");
    drive(1'b1, 1'b1, 1'b1, 3'h4, 3'h3, 1, 1, "R7 frozen");
    drive(1'b0, 1'b0, 1'b1, 3'h4, 3'h0, 0, 0, "R1 reinit");
    full_run(1'b1, "R9 stuck-at-1 run");
    drive(1'b1, 1'b1, 1'b0, 3'h4, 3'h0, 1, 0, "R9 frozen fail");
    drive(1'b0, 1'b0, 1'b0, 3'h4, 3'h0, 0, 0, "R1 reinit");
    drive(1'b1, 1'b1, 1'b0, 3'h2, 3'h0, 0, 0, "R10 partial");
    drive(1'b1, 1'b0, 1'b0, 3'h5, 3'h4, 0, 0, "R10 partial");
    drive(1'b1, 1'b0, 1'b0, 3'h6, 3'h6, 0, 0, "R10 partial");
    drive(1'b0, 1'b0, 1'b0, 3'h4, 3'h0, 0, 0, "R10 midrun init");
    drive(1'b1, 1'b0, 1'b0, 3'h4, 3'h0, 0, 0, "R10 idle after init");
    full_run(1'b0, "R10 rerun R8");
    drive(1'b1, 1'b0, 1'b0, 3'h4, 3'h3, 1, 1, "R7 frozen");
    repeat (2) @(posedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 5000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule